// File: doc/BRIEF.md
# Microcontroller Power-Mode Sequencer

This block moves a small 8-bit microcontroller core between three power states: run, idle and power-down. Software selects a state by writing a two-bit mode register. Bit 0 requests idle and bit 1 requests power-down. The block drives one clock enable for the CPU core and another for the peripherals (timers, serial port and interrupt logic). It also sets the levels of the external address-latch and program-fetch strobes.

Idle gates only the CPU clock, and an accepted interrupt ends it. Power-down gates every clock. Only an enabled external interrupt pin that is configured as level-sensitive and held low can end power-down. The oscillator restart is modelled as a qualification count on an always-on reference clock. The pin must stay low for at least `HOLD_CYCLES` reference clocks, and the wake completes when the pin is released. On that wake the block sends the CPU a one-cycle done pulse so that the interrupt can be vectored.

The block does not touch any register other than its mode bits, so state outside it is kept through both low-power modes. A hardware reset returns the block to run from any state.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode register reads 00, both clock enables are 1 and the wake-done pulse is 0.
- R2: In run, a write of 01 enters idle. The register then reads 01, the CPU clock enable is 0 and the peripheral clock enable stays 1.
- R3: In run, a write of 10 enters power-down. The register then reads 10 and both clock enables are 0.
- R4: A write of 11 enters power-down, and the register reads 10. At most one mode bit is ever set.
- R5: Register writes are accepted only in run. In idle or power-down a write leaves the register unchanged.
- R6: In idle, an interrupt-accepted strobe clears the idle bit, and the block is back in run after the next clock edge. No wake-done pulse is issued for this exit.
- R7: In power-down, the interrupt-accepted strobe has no effect.
- R8: In run the bus strobes follow the CPU's strobes. In idle both bus strobes are 1, and in power-down both are 0.
- R9: In power-down, only a pin whose enable bit is 1 and whose level-mode bit is 1 can start a wake, and only while that pin is driven low. Pins that are disabled or configured as edge-triggered are ignored.
- R10: A qualified pin that is held low for at least `HOLD_CYCLES` clock edges and then released returns the block to run, with the register reading 00. A release after fewer edges leaves the block in power-down, and the hold count starts again from zero.
- R11: A counted wake from power-down raises the wake-done output for exactly one cycle, in the same cycle that run is restored.
- R12: While a qualified pin stays low, the block remains in power-down, however far the hold extends past `HOLD_CYCLES`.
- R13: A hardware reset asserted in idle or in power-down returns the block to run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| pmode_we_i | input | 1 | Mode register write strobe |
| pmode_wdata_i | input | 2 | Mode write data (bit 0 idle, bit 1 power-down) |
| irq_accept_i | input | 1 | Interrupt accepted by the interrupt controller |
| ext_irq_ni | input | NUM_EXT_IRQ | External interrupt pins, active low |
| ext_irq_en_i | input | NUM_EXT_IRQ | Per-pin interrupt enable |
| ext_irq_level_i | input | NUM_EXT_IRQ | Per-pin level-sensitive mode (1) or edge mode (0) |
| cpu_addr_stb_i | input | 1 | Address-latch strobe from the CPU |
| cpu_fetch_stb_i | input | 1 | Program-fetch strobe from the CPU |
| pmode_q_o | output | 2 | Current mode register |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| bus_addr_stb_o | output | 1 | Address-latch strobe at the bus |
| bus_fetch_stb_o | output | 1 | Program-fetch strobe at the bus |
| wake_done_o | output | 1 | One-cycle pulse on a counted wake from power-down |

## Verification
A mode write and an interrupt-accepted strobe can arrive in the same cycle. The bench provokes this in both states where it matters:
- In run, the write must win and idle is entered.
- In idle, the accept must clear the idle bit and the write must be dropped.

In both cases the outcome is judged from the register read-back and the clock enables one edge later. The bench also places an accept strobe in power-down, and checks both one cycle later and at the end of a counted pin release, to show that only the pin release ends that state.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int IDLE_BIT = 0;
  localparam int DOWN_BIT = 1;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;
endpackage

// File: rtl/pwr_mode_reg.sv
`timescale 1ns/1ps
module pwr_mode_reg
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  input  logic       irq_accept_i,
  input  logic       wake_ok_i,
  output logic [1:0] pmode_q_o,
  output pmode_e     mode_o,
  output logic       wake_done_o
);
  logic [1:0] pmode_q, pmode_d;
  logic       done_q;

  assign mode_o = pmode_q[DOWN_BIT] ? PM_DOWN :
                  pmode_q[IDLE_BIT] ? PM_IDLE : PM_RUN;

  always_comb begin
    pmode_d = pmode_q;
    unique case (mode_o)
      PM_RUN: begin
        if (we_i) begin
          // power-down wins when both bits are written
          if (wdata_i[DOWN_BIT])      pmode_d = 2'b10;
          else if (wdata_i[IDLE_BIT]) pmode_d = 2'b01;
          else                        pmode_d = 2'b00;
        end
      end
      PM_IDLE: if (irq_accept_i) pmode_d = 2'b00;
      PM_DOWN: if (wake_ok_i)    pmode_d = 2'b00;
      default:                   pmode_d = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmode_q <= 2'b00;
      done_q  <= 1'b0;
    end else begin
      pmode_q <= pmode_d;
      done_q  <= (mode_o == PM_DOWN) && wake_ok_i;
    end
  end

  assign pmode_q_o   = pmode_q;
  assign wake_done_o = done_q;

  AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pmode_q)); // R4

  AST_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_q != 2'b00 && !wake_ok_i && !(pmode_q[IDLE_BIT] && irq_accept_i))
    |=> $stable(pmode_q)); // R5

  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_q == 2'b01 && irq_accept_i) |=> (pmode_q == 2'b00 && !done_q)); // R6

  AST_DOWN_ACCEPT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_q == 2'b10 && !wake_ok_i) |=> pmode_q == 2'b10); // R7
endmodule

// File: rtl/pwr_wake_qual.sv
`timescale 1ns/1ps
module pwr_wake_qual #(
  parameter int NUM_EXT_IRQ = 2,
  parameter int HOLD_CYCLES = 1024
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_down_i,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_ni,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_en_i,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_level_i,
  output logic                   wake_ok_o
);
  localparam int            CW     = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CYCLES);

  logic [NUM_EXT_IRQ-1:0] pin_qual;
  logic                   wake_req;
  logic [CW-1:0]          cnt_q;

  for (genvar g = 0; g < NUM_EXT_IRQ; g++) begin : g_pin
    assign pin_qual[g] = ext_irq_en_i[g] & ext_irq_level_i[g] & ~ext_irq_ni[g];
  end

  assign wake_req = |pin_qual;

  // saturating hold counter; any release or leaving power-down restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!in_down_i || !wake_req) cnt_q <= '0;
    else if (cnt_q != HOLD_C)        cnt_q <= cnt_q + 1'b1;
  end

  assign wake_ok_o = in_down_i && !wake_req && (cnt_q == HOLD_C);

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_down_i && !wake_req) |=> cnt_q == '0); // R10

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD_C); // R12

  AST_NO_WAKE_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req |-> !wake_ok_o); // R12
endmodule

// File: rtl/pwr_out_mux.sv
`timescale 1ns/1ps
module pwr_out_mux
  import pwr_seq_pkg::*;
(
  input  pmode_e mode_i,
  input  logic   cpu_addr_stb_i,
  input  logic   cpu_fetch_stb_i,
  output logic   cpu_clk_en_o,
  output logic   periph_clk_en_o,
  output logic   bus_addr_stb_o,
  output logic   bus_fetch_stb_o
);
  always_comb begin
    unique case (mode_i)
      PM_IDLE: begin
        cpu_clk_en_o    = 1'b0;
        periph_clk_en_o = 1'b1;
        bus_addr_stb_o  = 1'b1;
        bus_fetch_stb_o = 1'b1;
      end
      PM_DOWN: begin
        cpu_clk_en_o    = 1'b0;
        periph_clk_en_o = 1'b0;
        bus_addr_stb_o  = 1'b0;
        bus_fetch_stb_o = 1'b0;
      end
      default: begin
        cpu_clk_en_o    = 1'b1;
        periph_clk_en_o = 1'b1;
        bus_addr_stb_o  = cpu_addr_stb_i;
        bus_fetch_stb_o = cpu_fetch_stb_i;
      end
    endcase
  end
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_EXT_IRQ = 2,
  parameter int HOLD_CYCLES = 1024
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pmode_we_i,
  input  logic [1:0]             pmode_wdata_i,
  input  logic                   irq_accept_i,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_ni,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_en_i,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_level_i,
  input  logic                   cpu_addr_stb_i,
  input  logic                   cpu_fetch_stb_i,
  output logic [1:0]             pmode_q_o,
  output logic                   cpu_clk_en_o,
  output logic                   periph_clk_en_o,
  output logic                   bus_addr_stb_o,
  output logic                   bus_fetch_stb_o,
  output logic                   wake_done_o
);
  pmode_e mode;
  logic   wake_ok;

  pwr_mode_reg u_mode_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (pmode_we_i),
    .wdata_i      (pmode_wdata_i),
    .irq_accept_i (irq_accept_i),
    .wake_ok_i    (wake_ok),
    .pmode_q_o    (pmode_q_o),
    .mode_o       (mode),
    .wake_done_o  (wake_done_o)
  );

  pwr_wake_qual #(
    .NUM_EXT_IRQ (NUM_EXT_IRQ),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_wake_qual (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .in_down_i       (mode == PM_DOWN),
    .ext_irq_ni      (ext_irq_ni),
    .ext_irq_en_i    (ext_irq_en_i),
    .ext_irq_level_i (ext_irq_level_i),
    .wake_ok_o       (wake_ok)
  );

  pwr_out_mux u_out_mux (
    .mode_i          (mode),
    .cpu_addr_stb_i  (cpu_addr_stb_i),
    .cpu_fetch_stb_i (cpu_fetch_stb_i),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .bus_addr_stb_o  (bus_addr_stb_o),
    .bus_fetch_stb_o (bus_fetch_stb_o)
  );

  AST_DOWN_GATES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmode_q_o[DOWN_BIT] |-> (!cpu_clk_en_o && !periph_clk_en_o &&
                             !bus_addr_stb_o && !bus_fetch_stb_o)); // R3

  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_q_o == 2'b01) |-> (!cpu_clk_en_o && periph_clk_en_o &&
                              bus_addr_stb_o && bus_fetch_stb_o)); // R8

  AST_WAKE_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o); // R11

  AST_WAKE_FROM_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> (pmode_q_o == 2'b00 && $past(pmode_q_o[DOWN_BIT]))); // R10
endmodule

// File: tb/pwr_mode_seq_tb.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb;
  localparam int N    = 2;
  localparam int HOLD = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [1:0]   wdata = 2'b00;
  logic         acc = 1'b0;
  logic [N-1:0] pin_n = '1;
  logic [N-1:0] en = '0;
  logic [N-1:0] lvl = '0;
  logic         a_stb = 1'b0;
  logic         f_stb = 1'b0;
  logic [1:0]   pq;
  logic         cpu_en, per_en, b_a, b_f, wdone;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.NUM_EXT_IRQ(N), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pmode_we_i(we), .pmode_wdata_i(wdata),
    .irq_accept_i(acc), .ext_irq_ni(pin_n), .ext_irq_en_i(en),
    .ext_irq_level_i(lvl), .cpu_addr_stb_i(a_stb), .cpu_fetch_stb_i(f_stb),
    .pmode_q_o(pq), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
    .bus_addr_stb_o(b_a), .bus_fetch_stb_o(b_f), .wake_done_o(wdone)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {pcon, cpu_en, per_en, wake_done}
  function automatic logic [7:0] st();
    return {3'b0, pq, cpu_en, per_en, wdone};
  endfunction

  // {we, wdata[1:0], acc, exp_pcon[1:0], exp_cpu_en, exp_per_en}
  localparam logic [7:0] VEC [9] = '{
    8'b0_00_0_00_11,  // R1 idle cycle after reset
    8'b1_01_0_01_01,  // R2 enter idle
    8'b1_10_0_01_01,  // R5 write in idle ignored
    8'b0_00_1_00_11,  // R6 accept leaves idle
    8'b1_01_1_01_01,  // same-cycle write and accept in run: write wins
    8'b1_00_1_00_11,  // same-cycle in idle: accept wins, write dropped
    8'b1_11_0_10_00,  // R4 both bits -> power-down
    8'b0_00_1_10_00,  // R7 accept in power-down ignored
    8'b1_01_0_10_00   // R5 write in power-down ignored
  };

  task automatic hold_and_release(int idx, int edges);
    pin_n[idx] = 1'b0;
    repeat (edges) @(negedge clk);
    pin_n[idx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_mode(logic [1:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 2'b00;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", st(), {3'b0, 2'b00, 1'b1, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      {we, wdata, acc} = VEC[i][7:4];
      @(negedge clk);
      chk($sformatf("R2-R7 vector %0d", i), {4'b0, pq, cpu_en, per_en},
          {4'b0, VEC[i][3:0]});
      we = 1'b0; wdata = 2'b00; acc = 1'b0;
    end

    // R8 strobe levels in power-down
    a_stb = 1'b1; f_stb = 1'b1;
    #1 chk("R8 down strobes", {6'b0, b_a, b_f}, 8'h00);

    // R9 edge-mode pin and disabled pin ignored
    en = 2'b11; lvl = 2'b01;
    hold_and_release(1, HOLD + 5);
    chk("R9 edge pin", st(), {3'b0, 2'b10, 3'b000});
    en = 2'b01; lvl = 2'b11;
    hold_and_release(1, HOLD + 5);
    chk("R9 disabled pin", st(), {3'b0, 2'b10, 3'b000});

    // R10 short holds do not accumulate
    hold_and_release(0, HOLD - 1);
    chk("R10 short hold", st(), {3'b0, 2'b10, 3'b000});
    hold_and_release(0, HOLD - 1);
    chk("R10 count restarts", st(), {3'b0, 2'b10, 3'b000});

    // R12 long hold stays down, then R10/R11 wake
    acc = 1'b1;
    pin_n[0] = 1'b0;
    repeat (HOLD + 20) @(negedge clk);
    chk("R12 held past count", st(), {3'b0, 2'b10, 3'b000});
    pin_n[0] = 1'b1;
    @(negedge clk);
    acc = 1'b0;
    chk("R10 R11 wake", st(), {3'b0, 2'b00, 3'b111});
    @(negedge clk);
    chk("R11 pulse ends", st(), {3'b0, 2'b00, 3'b110});

    // R8 run pass-through
    a_stb = 1'b1; f_stb = 1'b0;
    #1 chk("R8 run strobes a", {6'b0, b_a, b_f}, 8'h02);
    a_stb = 1'b0; f_stb = 1'b1;
    #1 chk("R8 run strobes b", {6'b0, b_a, b_f}, 8'h01);

    // R3 plain power-down, exact-count wake
    @(negedge clk);
    write_mode(2'b10);
    chk("R3 enter down", st(), {3'b0, 2'b10, 3'b000});
    hold_and_release(0, HOLD);
    chk("R10 exact count", st(), {3'b0, 2'b00, 3'b111});

    // R8 idle levels, R13 reset from idle
    write_mode(2'b01);
    a_stb = 1'b0; f_stb = 1'b0;
    #1 chk("R8 idle strobes", {6'b0, b_a, b_f}, 8'h03);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R13 reset idle", st(), {3'b0, 2'b00, 3'b110});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset from power-down
    write_mode(2'b10);
    rst_n = 1'b0;
    #1 chk("R13 reset down", st(), {3'b0, 2'b00, 3'b110});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", st(), {3'b0, 2'b00, 3'b110});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule